// File: doc/BRIEF.md
# Keyed Watchdog with Early-Warning Timer

This block guards a system against a stalled processor. A 16-bit watchdog counter counts down on a slow tick. It pulses a reset output when it reaches zero, unless software rewrites it first by writing one specific key byte. A separate 24-bit warning timer counts on its own slow tick and raises a sticky interrupt before the watchdog is due to expire. Its handler can then record state before the reset arrives. Each timer draws its tick from a prescaler with four selectable division ratios. The second prescaler also drives a base timer that must be started before the watchdog will count.

Software reaches the block through a byte-wide register port with a write strobe, a 4-bit address, write data and combinational read data. A typical boot sequence runs as follows. Software clears the configuration register, sets key matching and the tick source, and programs both prescalers and the warning load. It starts the warning timer and the base timer, then loads the watchdog count (high byte, then low byte, and the low-byte write starts it). It then sets the lock code so that the watchdog setup can no longer be altered. From then on, a periodic routine rewrites the warning control and the key.

Top module: `kwdog_top`

## Requirements
- R1: After reset every register reads 0x00, the status register (address 0xC) reads 0x00, and both warnIrq and wdReset are low.
- R2: A prescaler select code of 0, 1, 2 or 3 (bits [1:0] of address 0x1 for the warning tick, address 0x6 for the base tick) gives one tick every DIV_SLOW, DIV_MID, DIV_FAST or 1 clocks. The phase count starts at zero after reset and again at each write to that select register.
- R3: A write to the warning control register (address 0x5) copies data bit 0 into the warning enable. When data bit 1 is set, it also reloads the warning count from the load bytes (0x2 low, 0x3 middle, 0x4 high) and clears warnIrq. While the timer is enabled, each warning tick decrements its count.
- R4: A warning tick that finds the enabled count at 1 or 0 leaves the count at 0, disables the timer and sets warnIrq. warnIrq stays high until a control write with bit 1 set.
- R5: The watchdog does not decrement until the base timer has been started by any write to address 0x7.
- R6: Writing address 0x9 stores the high count byte. Writing address 0xA loads the watchdog counter with {high byte, written byte} and marks it started.
- R7: Writing the KEY value (0x5C by default) to address 0xB reloads the started watchdog counter from the programmed high and low bytes, but only when configuration bit 4 is set. Any other value, or a key write while bit 4 is clear, leaves the count unchanged.
- R8: With configuration bit 5 set, the watchdog counts base ticks. With bit 5 clear, it counts warning ticks.
- R9: A watchdog tick that finds the count at 1 or 0 leaves it at 0 and drives wdReset high for exactly one clock. The counter then stays expired until reset, ignoring further starts, key writes and ticks. Status bit 1 reads 1 while expired.
- R10: When configuration bits [3:0] are all ones (for example after writing 0x3F), writes to addresses 0x6 to 0xA are ignored. The configuration register itself stays writable, and writing 0x00 unlocks.
- R11: While bit 0 of the watchdog control register (address 0x8) is set, the watchdog count holds its value.
- R12: Reads return the stored values of addresses 0x0 to 0xA and 0x0 for 0xB. Address 0xC reads {locked, started, expired, warnIrq} in bits [3:0]. Addresses 0xD and 0xE read the live watchdog count low and high bytes, and 0xF reads the live warning count low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for addr |
| warnIrq | output | 1 | Sticky early-warning interrupt |
| wdReset | output | 1 | One-clock reset pulse on watchdog expiry |

## Verification
The bench builds the block with DIV_SLOW=16, DIV_MID=4 and DIV_FAST=2. With these divisions the warning interrupt, the key-driven reload and a full watchdog expiry all occur within a few hundred clocks, instead of the millions that real tick rates would need. With such short divisions, the select-register phase restart, the pause hold, the choice of tick source and a zero warning load can each be observed on the live count reads within tens of cycles.

// File: rtl/kwdog_pkg.sv
`timescale 1ns/1ps
package kwdog_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int WARN_BYTES = 3;
  localparam int WARN_W = WARN_BYTES * DATA_W;
  localparam int WD_W = 2 * DATA_W;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG    = 4'h0,
    A_WPSR   = 4'h1,
    A_WLD0   = 4'h2,
    A_WLD1   = 4'h3,
    A_WLD2   = 4'h4,
    A_WCTL   = 4'h5,
    A_BPSR   = 4'h6,
    A_BSTART = 4'h7,
    A_DCTL   = 4'h8,
    A_DHI    = 4'h9,
    A_DLO    = 4'hA,
    A_KEY    = 4'hB,
    A_STAT   = 4'hC,
    A_DLIVEL = 4'hD,
    A_DLIVEH = 4'hE,
    A_WLIVE  = 4'hF
  } regAddr_e;

  typedef struct packed {
    logic warnCtlWr;
    logic warnEnBit;
    logic warnReload;
    logic warnPsrWr;
    logic basePsrWr;
    logic baseStart;
    logic wdStart;
    logic wdKick;
  } strobe_t;
endpackage

// File: rtl/kwdog_prescale.sv
`timescale 1ns/1ps
module kwdog_prescale #(
  parameter int DIV_SLOW = 4096,
  parameter int DIV_MID  = 1024,
  parameter int DIV_FAST = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sel,
  input  logic       restart,
  output logic       tick
);
  localparam int CW = $clog2(DIV_SLOW + 1);

  logic [CW-1:0] phase;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd0:    limit = CW'(DIV_SLOW - 1);
      2'd1:    limit = CW'(DIV_MID - 1);
      2'd2:    limit = CW'(DIV_FAST - 1);
      default: limit = '0;
    endcase
  end

  assign tick = (phase == limit);

  always_ff @(posedge clk) begin
    if (!rstN)                phase <= '0;
    else if (restart || tick) phase <= '0;
    else                      phase <= phase + 1'b1;
  end
endmodule

// File: rtl/kwdog_ctrl.sv
`timescale 1ns/1ps
module kwdog_ctrl
  import kwdog_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY = 8'h5C
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  output strobe_t             strb,
  output logic [DATA_W-1:0]   cfgReg,
  output logic [1:0]          warnSel,
  output logic [1:0]          baseSel,
  output logic [WARN_W-1:0]   warnLoad,
  output logic [DATA_W-1:0]   wdCtl,
  output logic [DATA_W-1:0]   wdHi,
  output logic [DATA_W-1:0]   wdLo,
  output logic [WD_W-1:0]     wdStartVal,
  output logic                locked,
  output logic                keyEn,
  output logic                srcBase
);
  logic [DATA_W-1:0] loadByte [WARN_BYTES];

  assign locked  = &cfgReg[3:0];
  assign keyEn   = cfgReg[4];
  assign srcBase = cfgReg[5];
  assign wdStartVal = {wdHi, wrData};

  function automatic logic hit(input regAddr_e a);
    return wrEn && (addr == a);
  endfunction

  always_comb begin
    strb.warnCtlWr  = hit(A_WCTL);
    strb.warnEnBit  = wrData[0];
    strb.warnReload = wrData[1];
    strb.warnPsrWr  = hit(A_WPSR);
    strb.basePsrWr  = hit(A_BPSR) && !locked;
    strb.baseStart  = hit(A_BSTART) && !locked;
    strb.wdStart    = hit(A_DLO) && !locked;
    strb.wdKick     = hit(A_KEY) && keyEn && (wrData == KEY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg  <= '0;
      warnSel <= '0;
      baseSel <= '0;
      wdCtl   <= '0;
      wdHi    <= '0;
      wdLo    <= '0;
    end else begin
      if (hit(A_CFG))  cfgReg  <= wrData;
      if (hit(A_WPSR)) warnSel <= wrData[1:0];
      if (strb.basePsrWr) baseSel <= wrData[1:0];
      if (hit(A_DCTL) && !locked) wdCtl <= wrData;
      if (hit(A_DHI)  && !locked) wdHi  <= wrData;
      if (strb.wdStart) wdLo <= wrData;
    end
  end

  for (genvar b = 0; b < WARN_BYTES; b++) begin : g_load
    always_ff @(posedge clk) begin
      if (!rstN) loadByte[b] <= '0;
      else if (wrEn && addr == ADDR_W'(int'(A_WLD0) + b)) loadByte[b] <= wrData;
    end
    assign warnLoad[b*DATA_W +: DATA_W] = loadByte[b];
  end
endmodule

// File: rtl/kwdog_datapath.sv
`timescale 1ns/1ps
module kwdog_datapath
  import kwdog_pkg::*;
#(
  parameter int DIV_SLOW = 4096,
  parameter int DIV_MID  = 1024,
  parameter int DIV_FAST = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        warnSel,
  input  logic [1:0]        baseSel,
  input  logic [WARN_W-1:0] warnLoad,
  input  logic [WD_W-1:0]   wdStartVal,
  input  logic [WD_W-1:0]   wdProg,
  input  logic              srcBase,
  input  logic              pause,
  output logic              warnIrq,
  output logic              warnEn,
  output logic [WARN_W-1:0] warnCnt,
  output logic              baseRun,
  output logic [WD_W-1:0]   wdCnt,
  output logic              wdStarted,
  output logic              wdExpired,
  output logic              wdReset
);
  logic [1:0] psSel     [2];
  logic       psRestart [2];
  logic       psTick    [2];

  assign psSel[0]     = warnSel;
  assign psSel[1]     = baseSel;
  assign psRestart[0] = strb.warnPsrWr;
  assign psRestart[1] = strb.basePsrWr;

  for (genvar i = 0; i < 2; i++) begin : g_ps
    kwdog_prescale #(
      .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)
    ) uPs (
      .clk(clk), .rstN(rstN), .sel(psSel[i]),
      .restart(psRestart[i]), .tick(psTick[i])
    );
  end

  logic warnTick, baseTick, wdTick;
  assign warnTick = psTick[0];
  assign baseTick = psTick[1];
  assign wdTick   = srcBase ? baseTick : warnTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnEn  <= 1'b0;
      warnCnt <= '0;
      warnIrq <= 1'b0;
    end else if (strb.warnCtlWr) begin
      warnEn <= strb.warnEnBit;
      if (strb.warnReload) begin
        warnCnt <= warnLoad;
        warnIrq <= 1'b0;
      end
    end else if (warnEn && warnTick) begin
      if (warnCnt <= WARN_W'(1)) begin
        warnCnt <= '0;
        warnIrq <= 1'b1;
        warnEn  <= 1'b0;
      end else begin
        warnCnt <= warnCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               baseRun <= 1'b0;
    else if (strb.baseStart) baseRun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt     <= '0;
      wdStarted <= 1'b0;
      wdExpired <= 1'b0;
      wdReset   <= 1'b0;
    end else begin
      wdReset <= 1'b0;
      if (!wdExpired) begin
        if (strb.wdStart) begin
          wdCnt     <= wdStartVal;
          wdStarted <= 1'b1;
        end else if (strb.wdKick && wdStarted) begin
          wdCnt <= wdProg;
        end else if (wdStarted && baseRun && !pause && wdTick) begin
          if (wdCnt <= WD_W'(1)) begin
            wdCnt     <= '0;
            wdExpired <= 1'b1;
            wdReset   <= 1'b1;
          end else begin
            wdCnt <= wdCnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/kwdog_top.sv
`timescale 1ns/1ps
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int DIV_SLOW = 4096,
  parameter int DIV_MID  = 1024,
  parameter int DIV_FAST = 32,
  parameter logic [7:0] KEY = 8'h5C
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [3:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       warnIrq,
  output logic       wdReset
);
  strobe_t           strb;
  logic [DATA_W-1:0] cfgReg, wdCtl, wdHi, wdLo;
  logic [1:0]        warnSel, baseSel;
  logic [WARN_W-1:0] warnLoad, warnCnt;
  logic [WD_W-1:0]   wdStartVal, wdCnt;
  logic              locked, keyEn, srcBase;
  logic              warnEn, baseRun, wdStarted, wdExpired;

  kwdog_ctrl #(.KEY(KEY)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .cfgReg(cfgReg), .warnSel(warnSel), .baseSel(baseSel),
    .warnLoad(warnLoad), .wdCtl(wdCtl), .wdHi(wdHi), .wdLo(wdLo),
    .wdStartVal(wdStartVal), .locked(locked), .keyEn(keyEn), .srcBase(srcBase)
  );

  kwdog_datapath #(
    .DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .warnSel(warnSel), .baseSel(baseSel),
    .warnLoad(warnLoad), .wdStartVal(wdStartVal), .wdProg({wdHi, wdLo}),
    .srcBase(srcBase), .pause(wdCtl[0]), .warnIrq(warnIrq), .warnEn(warnEn),
    .warnCnt(warnCnt), .baseRun(baseRun), .wdCnt(wdCnt), .wdStarted(wdStarted),
    .wdExpired(wdExpired), .wdReset(wdReset)
  );

  always_comb begin
    case (regAddr_e'(addr))
      A_CFG:    rdData = cfgReg;
      A_WPSR:   rdData = {6'b0, warnSel};
      A_WLD0:   rdData = warnLoad[7:0];
      A_WLD1:   rdData = warnLoad[15:8];
      A_WLD2:   rdData = warnLoad[23:16];
      A_WCTL:   rdData = {7'b0, warnEn};
      A_BPSR:   rdData = {6'b0, baseSel};
      A_BSTART: rdData = {7'b0, baseRun};
      A_DCTL:   rdData = wdCtl;
      A_DHI:    rdData = wdHi;
      A_DLO:    rdData = wdLo;
      A_STAT:   rdData = {4'b0, locked, wdStarted, wdExpired, warnIrq};
      A_DLIVEL: rdData = wdCnt[7:0];
      A_DLIVEH: rdData = wdCnt[15:8];
      A_WLIVE:  rdData = warnCnt[7:0];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/kwdog_chk.sv
`timescale 1ns/1ps
module kwdog_chk
  import kwdog_pkg::*;
#(
  parameter logic [7:0] KEY = 8'h5C
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [3:0]      addr,
  input logic [7:0]      wrData,
  input logic            warnIrq,
  input logic            wdReset,
  input logic            locked,
  input logic [7:0]      wdHi,
  input logic [WD_W-1:0] wdCnt,
  input logic            wdExpired
);
  logic seenRst;
  always_ff @(posedge clk) begin
    if (!rstN)        seenRst <= 1'b0;
    else if (wdReset) seenRst <= 1'b1;
  end

  // R9
  reset_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |=> !wdReset);
  // R9
  reset_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenRst |-> !wdReset);
  // R9
  reset_at_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> (wdCnt == '0) && wdExpired);
  // R9
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdExpired |=> wdExpired);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_DHI && locked) |=> $stable(wdHi));
  // R7
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_KEY && wrData != KEY) |=> (wdCnt <= $past(wdCnt)));
  // R4
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warnIrq && !(wrEn && addr == A_WCTL && wrData[1])) |=> warnIrq);
endmodule

bind kwdog_top kwdog_chk #(.KEY(KEY)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .warnIrq(warnIrq), .wdReset(wdReset), .locked(locked), .wdHi(wdHi),
  .wdCnt(wdCnt), .wdExpired(wdExpired)
);

// File: tb/kwdog_top_test.sv
`timescale 1ns/1ps
module kwdog_top_test;
  localparam int DS = 16, DM = 4, DF = 2;
  localparam logic [7:0] KEY = 8'h5C;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic warnIrq, wdReset;

  int nChecks = 0, nErr = 0, rstPulses = 0;
  bit cmpOn = 0, done = 0;

  kwdog_top #(.DIV_SLOW(DS), .DIV_MID(DM), .DIV_FAST(DF), .KEY(KEY)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .warnIrq(warnIrq), .wdReset(wdReset)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  int mCfg = 0, mWPsr = 0, mBPsr = 0, mWEn = 0, mWCnt = 0, mIrq = 0, mBRun = 0;
  int mDCtl = 0, mHi = 0, mLo = 0, mWd = 0, mStarted = 0, mExp = 0, mRst = 0;
  int mWPh = 0, mBPh = 0;
  int mLd[3] = '{0, 0, 0};

  function automatic int divOf(input int s);
    case (s)
      0: return DS;
      1: return DM;
      2: return DF;
      default: return 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 0; mWPsr = 0; mBPsr = 0; mWEn = 0; mWCnt = 0; mIrq = 0; mBRun = 0;
      mDCtl = 0; mHi = 0; mLo = 0; mWd = 0; mStarted = 0; mExp = 0; mRst = 0;
      mWPh = 0; mBPh = 0; mLd = '{0, 0, 0};
    end else begin
      bit lk, wT, bT, sT;
      lk = (mCfg % 16) == 15;
      wT = (mWPh == divOf(mWPsr) - 1);
      bT = (mBPh == divOf(mBPsr) - 1);
      sT = ((mCfg / 32) % 2 == 1) ? bT : wT;
      mRst = 0;
      if (mExp == 0) begin
        if (wrEn && addr == 4'hA && !lk) begin
          mWd = mHi * 256 + wrData; mStarted = 1;
        end else if (wrEn && addr == 4'hB && (mCfg / 16) % 2 == 1 && wrData == KEY
                     && mStarted == 1) begin
          mWd = mHi * 256 + mLo;
        end else if (mStarted == 1 && mBRun == 1 && mDCtl % 2 == 0 && sT) begin
          if (mWd <= 1) begin mWd = 0; mExp = 1; mRst = 1; end
          else mWd = mWd - 1;
        end
      end
      if (wrEn && addr == 4'h5) begin
        mWEn = wrData[0];
        if (wrData[1]) begin mWCnt = mLd[0] + 256 * mLd[1] + 65536 * mLd[2]; mIrq = 0; end
      end else if (mWEn == 1 && wT) begin
        if (mWCnt <= 1) begin mWCnt = 0; mIrq = 1; mWEn = 0; end
        else mWCnt = mWCnt - 1;
      end
      mWPh = ((wrEn && addr == 4'h1) || wT) ? 0 : mWPh + 1;
      mBPh = ((wrEn && addr == 4'h6 && !lk) || bT) ? 0 : mBPh + 1;
      if (wrEn) begin
        case (addr)
          4'h0: mCfg = wrData;
          4'h1: mWPsr = wrData % 4;
          4'h2: mLd[0] = wrData;
          4'h3: mLd[1] = wrData;
          4'h4: mLd[2] = wrData;
          4'h6: if (!lk) mBPsr = wrData % 4;
          4'h7: if (!lk) mBRun = 1;
          4'h8: if (!lk) mDCtl = wrData;
          4'h9: if (!lk) mHi = wrData;
          4'hA: if (!lk) mLo = wrData;
          default: ;
        endcase
      end
    end
  end

  // every-clock comparison of the outputs
  always @(negedge clk) begin
    if (cmpOn) begin
      nChecks++;
      if (warnIrq !== 1'(mIrq)) begin
        nErr++;
        $display("FAIL R4 warnIrq actual %0b expected %0d at %0t", warnIrq, mIrq, $time);
      end
      nChecks++;
      if (wdReset !== 1'(mRst)) begin
        nErr++;
        $display("FAIL R9 wdReset actual %0b expected %0d at %0t", wdReset, mRst, $time);
      end
      if (wdReset === 1'b1) rstPulses++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rdChk(input logic [3:0] a, input int exp, input string tag);
    addr = a; #0.5;
    nChecks++;
    if (rdData !== 8'(exp)) begin
      nErr++;
      $display("FAIL %s read addr %0h actual %0h expected %0h", tag, a, rdData, 8'(exp));
    end
  endtask

  task automatic bitChk(input logic act, input logic exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic int mStat();
    return ((mCfg % 16 == 15) ? 8 : 0) + mStarted * 4 + mExp * 2 + mIrq;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1; cmpOn = 1;
    // R1 reset state
    rdChk(4'hC, 0, "R1"); rdChk(4'h0, 0, "R1"); rdChk(4'hD, 0, "R1");
    bitChk(warnIrq, 1'b0, "R1"); bitChk(wdReset, 1'b0, "R1");

    // boot sequence, then lock
    wr(4'h0, 8'h00); wr(4'h1, 8'h01); wr(4'h6, 8'h01); wr(4'h0, 8'h30);
    wr(4'h8, 8'h00); wr(4'h2, 8'd20); wr(4'h3, 8'h00); wr(4'h4, 8'h00);
    wr(4'h5, 8'h03); wr(4'h7, 8'h01); wr(4'h9, 8'h00); wr(4'hA, 8'd60);
    rdChk(4'hD, 60, "R6"); rdChk(4'h2, 20, "R12");
    wr(4'h0, 8'h3F);
    // R10 locked writes ignored
    wr(4'h9, 8'h12); rdChk(4'h9, 0, "R10");
    wr(4'h8, 8'h01); rdChk(4'h8, 0, "R10");
    rdChk(4'hC, mStat(), "R10");
    idle(30); rdChk(4'hD, mWd, "R2");
    // R7 key reload
    wr(4'hB, KEY); rdChk(4'hD, 60, "R7"); rdChk(4'hE, 0, "R7");
    idle(20); wr(4'hB, 8'hA5); rdChk(4'hD, mWd, "R7");
    bitChk(rdData == 8'd60, 1'b0, "R7 wrong key");
    // R4 warning expiry, R3 acknowledge
    idle(100); bitChk(warnIrq, 1'b1, "R4"); rdChk(4'hF, 0, "R4");
    rdChk(4'h5, 0, "R4");
    wr(4'h5, 8'h03); bitChk(warnIrq, 1'b0, "R3"); rdChk(4'hF, 20, "R3");
    repeat (5) begin idle(100); wr(4'hB, KEY); end
    rdChk(4'hC, mStat(), "R7"); bitChk(rstPulses == 0, 1'b1, "R7 kicks");
    // R9 expiry
    idle(300);
    rdChk(4'hC, mStat(), "R9"); bitChk(rdData[1], 1'b1, "R9");
    bitChk(rstPulses == 1, 1'b1, "R9 single pulse");
    wr(4'hB, KEY); rdChk(4'hD, 0, "R9");
    idle(50); bitChk(rstPulses == 1, 1'b1, "R9 no repeat");

    // second run: R5, R11, R8, R2
    @(posedge clk); #1 rstN = 1'b0; idle(2); rstN = 1'b1;
    rdChk(4'hC, 0, "R1");
    wr(4'h0, 8'h30); wr(4'h6, 8'h01); wr(4'h9, 8'h00); wr(4'hA, 8'd10);
    idle(50); rdChk(4'hD, 10, "R5");
    wr(4'h7, 8'h01); idle(20); rdChk(4'hD, mWd, "R5");
    bitChk(rdData < 8'd10, 1'b1, "R5 counting");
    wr(4'hB, KEY);
    wr(4'h8, 8'h01);
    begin
      int held;
      held = mWd;
      idle(30); rdChk(4'hD, held, "R11");
    end
    wr(4'h8, 8'h00);
    wr(4'h0, 8'h10); wr(4'h1, 8'h03); wr(4'hB, KEY);
    idle(4); rdChk(4'hD, mWd, "R8");
    wr(4'h0, 8'h30); wr(4'h6, 8'h02); wr(4'hB, KEY);
    idle(7); rdChk(4'hD, mWd, "R2");
    wr(4'h0, 8'h20); idle(3); wr(4'hB, KEY); rdChk(4'hD, mWd, "R7 key disabled");
    // R12 read map, R4 zero load
    wr(4'h4, 8'hAB); rdChk(4'h4, 8'hAB, "R12"); rdChk(4'h7, 1, "R12");
    wr(4'h2, 8'h00); wr(4'h3, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h03);
    idle(10); bitChk(warnIrq, 1'b1, "R4 zero load");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end
endmodule